// File: doc/BRIEF.md
# TCP/UDP Header Sanity Checker

This block sits after an IP header parser in a packet receive path and judges whether the layer-4 header of a received packet is plausible. The parser presents, in one cycle with a valid strobe, the IP protocol number, the source and destination ports, the UDP length field, the payload length that the IP header declares, the six TCP control flags, a checksum mismatch indication from a separate checksum engine, and four status flags from the earlier stages: receive error, non-IP, IP header exception and fragment.

One cycle after the strobe the block pulses `done` and presents a registered result. The result holds an error flag, an 8-bit numeric error code and an indication that the packet carries TCP or UDP. When more than one problem is present, the lowest-numbered code wins. Any earlier-stage problem or fragmentation suppresses the layer-4 verdict, because the header bytes cannot be trusted or are not present in that case. The result stays on the outputs until the next strobe.

Top module: `l4_sanity_check`

## Requirements
- R1: `done` is high exactly in the cycle after a cycle with `in_valid` high. `l4_err`, `err_code` and `tcp_or_udp` are updated only on a strobe and hold their values otherwise. Synchronous active-high `rst` clears all outputs to zero.
- R2: If `rx_err`, `non_ip`, `ip_hdr_err` or `frag` is set with the strobe, `l4_err` is 0 and `err_code` is 0.
- R3: Protocol number 6 is TCP and 17 is UDP. `tcp_or_udp` is 1 exactly when `non_ip` is 0 and the protocol is 6 or 17. Any other protocol gives `l4_err` = 0, whatever the other inputs are.
- R4: Code 2: `csum_bad` is set for a TCP or UDP packet.
- R5: Code 3: for UDP only, `udp_len` is strictly greater than `ip_pay_len`. Equal values are legal, and the field is ignored for TCP.
- R6: Code 4: the source port or the destination port is zero.
- R7: Code 8: TCP with FIN as the only flag set. The flag bit positions are FIN=0, SYN=1, RST=2, PSH=3, ACK=4, URG=5.
- R8: Code 9: TCP with all six flags clear.
- R9: Code 10: TCP with FIN and RST both set, whatever the other flags are.
- R10: Code 11: TCP with SYN and URG both set.
- R11: Code 12: TCP with SYN and RST both set.
- R12: Code 13: TCP with SYN and FIN both set. The flag checks do not apply to UDP.
- R13: When several conditions hold, the reported code is the lowest applicable one. For example, SYN+FIN+RST gives 10.
- R14: `l4_err` is 1 exactly when `err_code` is nonzero. A clear flag always comes with code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Header fields valid this cycle |
| ip_proto | input | 8 | IP protocol number |
| src_port | input | 16 | L4 source port |
| dst_port | input | 16 | L4 destination port |
| udp_len | input | 16 | UDP length field |
| ip_pay_len | input | 16 | Payload length declared by the IP header |
| tcp_flags | input | 6 | TCP flags, FIN in bit 0 to URG in bit 5 |
| csum_bad | input | 1 | External L4 checksum mismatch |
| rx_err | input | 1 | Earlier receive error |
| non_ip | input | 1 | Packet not recognised as IP |
| ip_hdr_err | input | 1 | IP header exception |
| frag | input | 1 | Packet is an IP fragment |
| done | output | 1 | Result valid pulse |
| l4_err | output | 1 | L4 error found |
| err_code | output | 8 | L4 error code |
| tcp_or_udp | output | 1 | Packet is TCP or UDP |

## Verification
Clean TCP and UDP headers establish that legal traffic passes, including a UDP length exactly equal to the IP payload length. Each single fault is applied alone to show that every code maps to its own condition. Stacked faults, such as checksum with a bad length and a zero port, or SYN+FIN+RST, separate a correct priority order from a wrong one. Each suppression flag and foreign protocols are applied together with faults that would otherwise fire. TCP packets with an oversized UDP length and UDP packets with no flags show that the checks do not leak between protocols. Holding the inputs and changing them with no strobe shows that the result is held and `done` is a single-cycle pulse.

// File: rtl/l4chk_pkg.sv
package l4chk_pkg;
  localparam int FLAG_W = 6;
  localparam int NRULE  = 6;
  localparam logic [7:0] C_NONE = 8'd0;
  localparam logic [7:0] C_CSUM = 8'd2;
  localparam logic [7:0] C_ULEN = 8'd3;
  localparam logic [7:0] C_PORT = 8'd4;
  localparam logic [7:0] C_RULE_BASE = 8'd8;

  // Flag rules in ascending code order: 8 FIN only, 9 none, 10 FIN+RST,
  // 11 SYN+URG, 12 SYN+RST, 13 SYN+FIN. Bits: FIN0 SYN1 RST2 PSH3 ACK4 URG5.
  function automatic logic [FLAG_W-1:0] rule_mask(int i);
    case (i)
      0:       return 6'b000001;
      1:       return 6'b000000;
      2:       return 6'b000101;
      3:       return 6'b100010;
      4:       return 6'b000110;
      default: return 6'b000011;
    endcase
  endfunction

  // Exact rules compare the whole flag field; the others need the mask bits set.
  function automatic bit rule_exact(int i);
    return i < 2;
  endfunction

  function automatic logic [7:0] rule_code(int i);
    return C_RULE_BASE + 8'(i);
  endfunction
endpackage

// File: rtl/l4_port_zero.sv
module l4_port_zero #(
  parameter int PORT_W = 16
) (
  input  logic [PORT_W-1:0] src_port,
  input  logic [PORT_W-1:0] dst_port,
  output logic              hit
);
  assign hit = (src_port == '0) || (dst_port == '0);
endmodule

// File: rtl/l4_udp_len_check.sv
module l4_udp_len_check #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] udp_len,
  input  logic [LEN_W-1:0] ip_pay_len,
  output logic             hit
);
  // An equal length is legal; only a length that runs past the payload fails.
  assign hit = udp_len > ip_pay_len;
endmodule

// File: rtl/l4_tcp_flag_rules.sv
module l4_tcp_flag_rules
  import l4chk_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  output logic [NRULE-1:0]  hit
);
  for (genvar g = 0; g < NRULE; g++) begin : g_rule
    localparam logic [FLAG_W-1:0] MASK = rule_mask(g);
    if (rule_exact(g)) begin : g_exact
      assign hit[g] = (flags == MASK);
    end else begin : g_all
      assign hit[g] = ((flags & MASK) == MASK);
    end
  end
endmodule

// File: rtl/l4_sanity_check.sv
module l4_sanity_check
  import l4chk_pkg::*;
#(
  parameter int PORT_W  = 16,
  parameter int LEN_W   = 16,
  parameter int PROTO_W = 8,
  parameter int CODE_W  = 8,
  parameter logic [PROTO_W-1:0] PROTO_TCP = 8'd6,
  parameter logic [PROTO_W-1:0] PROTO_UDP = 8'd17
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [PROTO_W-1:0] ip_proto,
  input  logic [PORT_W-1:0]  src_port,
  input  logic [PORT_W-1:0]  dst_port,
  input  logic [LEN_W-1:0]   udp_len,
  input  logic [LEN_W-1:0]   ip_pay_len,
  input  logic [FLAG_W-1:0]  tcp_flags,
  input  logic               csum_bad,
  input  logic               rx_err,
  input  logic               non_ip,
  input  logic               ip_hdr_err,
  input  logic               frag,
  output logic               done,
  output logic               l4_err,
  output logic [CODE_W-1:0]  err_code,
  output logic               tcp_or_udp
);
  logic             port_hit, len_hit;
  logic [NRULE-1:0] rule_hit;
  logic             is_tcp, is_udp, l4_known, judge;
  logic [7:0]       code_nxt;

  l4_port_zero #(.PORT_W(PORT_W)) u_port (
    .src_port(src_port), .dst_port(dst_port), .hit(port_hit));

  l4_udp_len_check #(.LEN_W(LEN_W)) u_len (
    .udp_len(udp_len), .ip_pay_len(ip_pay_len), .hit(len_hit));

  l4_tcp_flag_rules u_flags (.flags(tcp_flags), .hit(rule_hit));

  assign is_tcp   = (ip_proto == PROTO_TCP);
  assign is_udp   = (ip_proto == PROTO_UDP);
  assign l4_known = (is_tcp || is_udp) && !non_ip;
  assign judge    = l4_known && !rx_err && !ip_hdr_err && !frag;

  // Lowest code wins: checksum, UDP length, port, then flag rules ascending.
  always_comb begin
    code_nxt = C_NONE;
    if (judge) begin
      if (csum_bad) begin
        code_nxt = C_CSUM;
      end else if (is_udp && len_hit) begin
        code_nxt = C_ULEN;
      end else if (port_hit) begin
        code_nxt = C_PORT;
      end else if (is_tcp) begin
        for (int i = NRULE - 1; i >= 0; i--) begin
          if (rule_hit[i]) code_nxt = rule_code(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done       <= 1'b0;
      l4_err     <= 1'b0;
      err_code   <= '0;
      tcp_or_udp <= 1'b0;
    end else begin
      done <= in_valid;
      if (in_valid) begin
        l4_err     <= (code_nxt != C_NONE);
        err_code   <= CODE_W'(code_nxt);
        tcp_or_udp <= l4_known;
      end
    end
  end

  a_r1_done_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> done);
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!done && $stable(err_code) && $stable(l4_err)));
  a_r2_suppress: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (rx_err || non_ip || ip_hdr_err || frag)) |=> !l4_err);
  a_r3_err_needs_l4: assert property (@(posedge clk) disable iff (rst)
    l4_err |-> tcp_or_udp);
  a_r14_clear_zero: assert property (@(posedge clk) disable iff (rst)
    !l4_err |-> (err_code == '0));
  a_r13_csum_first: assert property (@(posedge clk) disable iff (rst)
    (in_valid && judge && csum_bad) |=> (err_code == CODE_W'(C_CSUM)));
endmodule

// File: tb/tb_l4_sanity_check.sv
module tb_l4_sanity_check;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  ip_proto = '0;
  logic [15:0] src_port = '0, dst_port = '0, udp_len = '0, ip_pay_len = '0;
  logic [5:0]  tcp_flags = '0;
  logic        csum_bad = 0, rx_err = 0, non_ip = 0, ip_hdr_err = 0, frag = 0;
  logic        done, l4_err, tcp_or_udp;
  logic [7:0]  err_code;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  l4_sanity_check dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ip_proto(ip_proto),
    .src_port(src_port), .dst_port(dst_port), .udp_len(udp_len),
    .ip_pay_len(ip_pay_len), .tcp_flags(tcp_flags), .csum_bad(csum_bad),
    .rx_err(rx_err), .non_ip(non_ip), .ip_hdr_err(ip_hdr_err), .frag(frag),
    .done(done), .l4_err(l4_err), .err_code(err_code), .tcp_or_udp(tcp_or_udp));

  typedef struct packed {
    logic [7:0]  proto;
    logic [15:0] sp, dp, ulen, plen;
    logic [5:0]  fl;
    logic        cs, rx, nip, ipe, frg;
    logic        e;
    logic [7:0]  code;
    logic        tu;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h10, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'd0,  1'b1, 8'd3},  // R3 clean TCP
    '{8'd17, 16'd53,   16'd53, 16'd20, 16'd20, 6'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'd0,  1'b1, 8'd5},  // R5 equal len, R12 no UDP flags
    '{8'd17, 16'd53,   16'd53, 16'd21, 16'd20, 6'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd3,  1'b1, 8'd5},  // R5
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h10, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd2,  1'b1, 8'd4},  // R4
    '{8'd6,  16'd0,    16'd80, 16'd0,  16'd40, 6'h10, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd4,  1'b1, 8'd6},  // R6
    '{8'd17, 16'd53,   16'd0,  16'd8,  16'd20, 6'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd4,  1'b1, 8'd6},  // R6
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h01, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd8,  1'b1, 8'd7},  // R7
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd9,  1'b1, 8'd8},  // R8
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h05, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd10, 1'b1, 8'd9},  // R9
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h22, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd11, 1'b1, 8'd10}, // R10
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h06, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd12, 1'b1, 8'd11}, // R11
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h03, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd13, 1'b1, 8'd12}, // R12
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h07, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd10, 1'b1, 8'd13}, // R13 SYN+FIN+RST
    '{8'd6,  16'd0,    16'd80, 16'd0,  16'd40, 6'h00, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd2,  1'b1, 8'd13}, // R13
    '{8'd17, 16'd0,    16'd53, 16'd99, 16'd20, 6'h00, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd2,  1'b1, 8'd13}, // R13
    '{8'd17, 16'd0,    16'd53, 16'd99, 16'd20, 6'h00, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd3,  1'b1, 8'd13}, // R13
    '{8'd6,  16'd0,    16'd80, 16'd0,  16'd40, 6'h01, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b1, 8'd4,  1'b1, 8'd13}, // R13
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h00, 1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0, 8'd0,  1'b1, 8'd2},  // R2 frag
    '{8'd6,  16'd0,    16'd80, 16'd0,  16'd40, 6'h00, 1'b1,1'b1,1'b0,1'b0,1'b0, 1'b0, 8'd0,  1'b1, 8'd2},  // R2 rx_err
    '{8'd6,  16'd0,    16'd80, 16'd0,  16'd40, 6'h00, 1'b1,1'b0,1'b1,1'b0,1'b0, 1'b0, 8'd0,  1'b0, 8'd2},  // R2 non_ip
    '{8'd17, 16'd0,    16'd53, 16'd99, 16'd20, 6'h00, 1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0, 8'd0,  1'b1, 8'd2},  // R2 ip_hdr_err
    '{8'd1,  16'd0,    16'd0,  16'd99, 16'd20, 6'h00, 1'b1,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'd0,  1'b0, 8'd3},  // R3 other proto
    '{8'd6,  16'd1000, 16'd80, 16'd99, 16'd20, 6'h12, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'd0,  1'b1, 8'd5},  // R5 ignored for TCP
    '{8'd6,  16'd1000, 16'd80, 16'd0,  16'd40, 6'h11, 1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0, 8'd0,  1'b1, 8'd7}   // R7 FIN+ACK legal
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    ip_proto = v.proto; src_port = v.sp; dst_port = v.dp; udp_len = v.ulen;
    ip_pay_len = v.plen; tcp_flags = v.fl; csum_bad = v.cs; rx_err = v.rx;
    non_ip = v.nip; ip_hdr_err = v.ipe; frag = v.frg; in_valid = vld;
  endtask

  task automatic check_result(input vec_t v, input int idx);
    string t;
    t = $sformatf("R%0d vec%0d", v.req, idx);
    chk({t, " done (R1)"}, done, 1);
    chk({t, " l4_err"}, l4_err, v.e);
    chk({t, " code"}, err_code, v.code);
    chk({t, " tcp_or_udp"}, tcp_or_udp, v.tu);
    chk({t, " flag/code agree (R14)"}, l4_err, err_code != 0);
  endtask

  initial begin
    #1500000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset done", done, 0);
    chk("R1 reset l4_err", l4_err, 0);
    chk("R1 reset code", err_code, 0);
    chk("R1 reset tcp_or_udp", tcp_or_udp, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i], 1'b1);
      @(negedge clk);
      in_valid = 1'b0;
      check_result(VEC[i], i);
    end

    // R1 hold: produce code 13, then change inputs without a strobe
    @(negedge clk); drive(VEC[11], 1'b1);
    @(negedge clk); drive(VEC[0], 1'b0);
    chk("R12 setup code", err_code, 13);
    @(negedge clk);
    chk("R1 done single pulse", done, 0);
    chk("R1 code held", err_code, 13);
    chk("R1 flag held", l4_err, 1);

    // R1 back-to-back strobes
    @(negedge clk); drive(VEC[2], 1'b1);
    @(negedge clk); drive(VEC[7], 1'b1);
    chk("R1 b2b first code", err_code, 3);
    chk("R1 b2b first done", done, 1);
    @(negedge clk); in_valid = 1'b0;
    chk("R1 b2b second code", err_code, 9);
    chk("R1 b2b second done", done, 1);

    // R1 reset clears a held error
    rst = 1'b1;
    @(negedge clk);
    chk("R1 reset clears code", err_code, 0);
    chk("R1 reset clears flag", l4_err, 0);
    chk("R1 reset clears tu", tcp_or_udp, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule